// File: doc/BRIEF.md
# Channel Request-Enable Register Bank

This block keeps one request-enable bit per channel for a multi-channel transfer controller, and a second per-channel vector that decides which channel error flags may raise the shared error interrupt. Software reaches both vectors through a generic single-cycle register port. Each vector is split into 32-bit words that can be read and written directly. The enable vector goes out on a port so that the request arbiter can mask requests with it.

Software can also change one channel without a read-modify-write. It writes the channel number into the low seven bits of a command register. A write to the set-command register turns that channel's enable on. A write to the clear-command register turns it off. When bit 6 of the command is set, the command acts on every channel at once. Both command registers read as zero. The bank can be built with 64 channels or with 32. In the 32-channel build, channel numbers 32 to 63 do nothing.

Top module: `req_enable_bank`

## Requirements
- R1: After reset, every enable bit and every error-interrupt enable bit is 0, every readable word returns 0, and `err_irq` is 0.
- R2: Direct word access works on both vectors. Offset 0x00 holds enable channels 31..0 and offset 0x04 holds channels 63..32, with bit k of a word being channel 32*w+k. Each word reads back the last value written. Offsets that are not mapped read as 0.
- R3: A write to the set-command register (offset 0x18) with bits 6..0 between 0 and 63 sets the enable bit of that channel number and leaves every other bit unchanged.
- R4: A write to offset 0x18 with bit 6 set (values 64 to 127) sets every enable bit.
- R5: A write to the clear-command register (offset 0x1C) with bits 6..0 between 0 and 63 clears only that channel's enable bit.
- R6: A write to offset 0x1C with bit 6 set clears every enable bit.
- R7: Offsets 0x18 and 0x1C always read as 0.
- R8: A command takes only data bits 6..0. Bit 7 and bits 31..8 of the written word have no effect on the command.
- R9: With 32 channels, a command for channel 32 to 63 leaves the enable vector unchanged. Offsets 0x04 and 0x0C then read 0 and ignore writes.
- R10: The error-interrupt enable words sit at 0x08 (channels 31..0) and 0x0C (channels 63..32). They read back what was written.
- R11: `err_irq` is 1 exactly when some channel has both its error flag and its error-interrupt enable bit at 1. It is registered, so it follows its inputs one clock later.
- R12: `req_enable` always equals the enable vector seen through the direct words, and it changes on the clock edge that commits a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| err_flags | input | NUM_CH | Per-channel error flags |
| req_enable | output | NUM_CH | Per-channel request-enable vector |
| err_irq | output | 1 | Gated OR of the error flags, registered |

## Verification
Every channel number from 0 to 63 is sent through both command registers, on a 64-channel bank and a 32-channel bank side by side. This shows up a decoder that is off by one, that folds channels 32..63 onto the low word, or that lets the reserved numbers touch the 32-channel bank. The global commands are sent with mixed values in bits 5..0 and with junk in bit 7 and the upper bits. A decoder that read bit 7, or that used the low bits next to a set bit 6, would then leave a partial vector behind. The interrupt gating is swept one channel at a time, with the flag on and the enable off and then the reverse. A design that let an ungated error through, or that did not register the output, would show a wrong `err_irq` in the cycle that is sampled.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CMD_W  = 7;

    localparam logic [ADDR_W-1:0] OFS_EN_BASE  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_EIE_BASE = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_SET_CMD  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CLR_CMD  = 8'h1C;
    localparam int                WORD_STRIDE  = 4;
endpackage

// File: rtl/chan_cmd_decode.sv
module chan_cmd_decode #(
    parameter int NUM_CH = 64
) (
    input  logic                            valid,
    input  logic [regbank_pkg::CMD_W-1:0]   cmd,
    output logic [NUM_CH-1:0]               mask
);
    localparam int IDX_W = regbank_pkg::CMD_W - 1;

    logic global_hit;
    assign global_hit = cmd[IDX_W];

    // A channel above NUM_CH-1 has no comparator, so it selects nothing.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign mask[i] = valid & (global_hit | (cmd[IDX_W-1:0] == IDX_W'(i)));
    end
endmodule

// File: rtl/err_irq_gen.sv
module err_irq_gen #(
    parameter int NUM_CH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] err_flags,
    input  logic [NUM_CH-1:0] irq_en,
    output logic              irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = |(err_flags & irq_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    // R11
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(err_flags & irq_en))));
endmodule

// File: rtl/req_enable_bank.sv
module req_enable_bank #(
    parameter int NUM_CH = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [regbank_pkg::ADDR_W-1:0]  addr,
    input  logic [regbank_pkg::DATA_W-1:0]  wdata,
    output logic [regbank_pkg::DATA_W-1:0]  rdata,
    input  logic [NUM_CH-1:0]               err_flags,
    output logic [NUM_CH-1:0]               req_enable,
    output logic                            err_irq
);
    import regbank_pkg::*;

    localparam int WORDS = NUM_CH / DATA_W;
    localparam int CW    = CMD_W;

    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [NUM_CH-1:0] eie;
    } bank_t;

    bank_t s_d, s_q;
    logic  set_hit, clr_hit;
    logic [NUM_CH-1:0] set_mask, clr_mask;

    assign set_hit = wr_en && (addr == OFS_SET_CMD);
    assign clr_hit = wr_en && (addr == OFS_CLR_CMD);

    chan_cmd_decode #(.NUM_CH(NUM_CH)) u_set_dec (
        .valid (set_hit),
        .cmd   (wdata[CW-1:0]),
        .mask  (set_mask)
    );

    chan_cmd_decode #(.NUM_CH(NUM_CH)) u_clr_dec (
        .valid (clr_hit),
        .cmd   (wdata[CW-1:0]),
        .mask  (clr_mask)
    );

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            for (int w = 0; w < WORDS; w++) begin
                if (addr == ADDR_W'(int'(OFS_EN_BASE) + WORD_STRIDE * w))
                    s_d.en[DATA_W*w +: DATA_W] = wdata;
                if (addr == ADDR_W'(int'(OFS_EIE_BASE) + WORD_STRIDE * w))
                    s_d.eie[DATA_W*w +: DATA_W] = wdata;
            end
        end
        // Command actions override a direct write; clear beats set.
        s_d.en = (s_d.en | set_mask) & ~clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (addr == ADDR_W'(int'(OFS_EN_BASE) + WORD_STRIDE * w))
                rdata = s_q.en[DATA_W*w +: DATA_W];
            if (addr == ADDR_W'(int'(OFS_EIE_BASE) + WORD_STRIDE * w))
                rdata = s_q.eie[DATA_W*w +: DATA_W];
        end
    end

    assign req_enable = s_q.en;

    err_irq_gen #(.NUM_CH(NUM_CH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_flags (err_flags),
        .irq_en    (s_q.eie),
        .irq       (err_irq)
    );

    // R3
    set_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hit && !wdata[CW-1] && (int'(wdata[CW-2:0]) < NUM_CH))
        |=> (((req_enable >> $past(wdata[CW-2:0])) & NUM_CH'(1)) != '0));

    // R4
    set_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hit && wdata[CW-1]) |=> (&req_enable));

    // R5
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !wdata[CW-1] && (int'(wdata[CW-2:0]) < NUM_CH))
        |=> (((req_enable >> $past(wdata[CW-2:0])) & NUM_CH'(1)) == '0));

    // R6
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && wdata[CW-1]) |=> (req_enable == '0));

    // R7
    cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr == OFS_SET_CMD) || (addr == OFS_CLR_CMD)) |-> (rdata == '0));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(req_enable));

    if (NUM_CH == DATA_W) begin : g_narrow_chk
        // R9
        reserved_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((set_hit || clr_hit) && !wdata[CW-1] && wdata[CW-2])
            |=> $stable(req_enable));
    end
endmodule

// File: tb/sim_req_enable_bank.sv
`timescale 1ns/1ps
module sim_req_enable_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic [63:0] err64 = '0;
    logic [63:0] en0;
    logic [31:0] en1;
    logic        irq0, irq1;

    logic [63:0] m64, e64;
    logic [31:0] m32, e32;
    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    req_enable_bank #(.NUM_CH(64)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata0), .err_flags(err64), .req_enable(en0), .err_irq(irq0));

    req_enable_bank #(.NUM_CH(32)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata1), .err_flags(err64[31:0]), .req_enable(en1), .err_irq(irq1));

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model built from the requirements.
    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        logic [6:0] c;
        c = d[6:0];
        case (a)
            8'h00: begin m64[31:0] = d; m32 = d; end
            8'h04: m64[63:32] = d;
            8'h08: begin e64[31:0] = d; e32 = d; end
            8'h0C: e64[63:32] = d;
            8'h18: begin
                if (c[6]) begin m64 = '1; m32 = '1; end
                else begin
                    m64[c[5:0]] = 1'b1;
                    if (!c[5]) m32[c[4:0]] = 1'b1;
                end
            end
            8'h1C: begin
                if (c[6]) begin m64 = '0; m32 = '0; end
                else begin
                    m64[c[5:0]] = 1'b0;
                    if (!c[5]) m32[c[4:0]] = 1'b0;
                end
            end
            default: ;
        endcase
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h10; wdata = '0;
        model_write(a, d);
    endtask

    task automatic chk_vec(input string req);
        check(en0 == m64, req, en0, m64);
        check(en1 == m32, req, {32'h0, en1}, {32'h0, m32});
    endtask

    task automatic chk_read(input logic [7:0] a, input logic [31:0] x0,
                            input logic [31:0] x1, input string req);
        addr = a; #1;
        check(rdata0 == x0, req, {32'h0, rdata0}, {32'h0, x0});
        check(rdata1 == x1, req, {32'h0, rdata1}, {32'h0, x1});
        addr = 8'h10;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m64 = '0; m32 = '0; e64 = '0; e32 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_vec("R1");
        check(irq0 == 1'b0 && irq1 == 1'b0, "R1", {62'h0, irq1, irq0}, 64'h0);
        for (int a = 0; a < 32; a += 4) chk_read(8'(a), 32'h0, 32'h0, "R1");

        // R2 / R10 direct words, R9 narrow upper words
        wr(8'h00, 32'hA5A5_0F0F);
        wr(8'h04, 32'h1234_5678);
        wr(8'h08, 32'hDEAD_BEEF);
        wr(8'h0C, 32'h0BAD_F00D);
        chk_read(8'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F, "R2");
        chk_read(8'h04, 32'h1234_5678, 32'h0, "R2 R9");
        chk_read(8'h08, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R10");
        chk_read(8'h0C, 32'h0BAD_F00D, 32'h0, "R10 R9");
        chk_read(8'h14, 32'h0, 32'h0, "R2 unmapped");
        chk_vec("R12");

        // R7 command registers read zero
        chk_read(8'h18, 32'h0, 32'h0, "R7");
        chk_read(8'h1C, 32'h0, 32'h0, "R7");

        // R3/R5/R8/R9 per-channel sweep through both command registers
        for (int ch = 0; ch < 64; ch++) begin
            wr(8'h1C, 32'h0000_0040);
            wr(8'h18, (ch % 2 == 1) ? (32'hFFFF_FF80 | 32'(ch)) : 32'(ch));
            chk_vec("R3 R8 R9");
            chk_read(8'h00, m64[31:0], m32, "R3 R12");
            wr(8'h18, 32'h0000_0040 | 32'((ch * 7) % 64));
            chk_vec("R4");
            wr(8'h1C, (ch % 3 == 0) ? (32'h5A5A_5A80 | 32'(ch)) : 32'(ch));
            chk_vec("R5 R8 R9");
            chk_read(8'h04, m64[63:32], 32'h0, "R5 R12");
        end

        // R6 global clear with junk in low bits and bit 7
        wr(8'h18, 32'h0000_007F);
        chk_vec("R4");
        wr(8'h1C, 32'hFFFF_FFD5);
        chk_vec("R6");
        check(en0 == 64'h0, "R6", en0, 64'h0);

        // R8 bit 7 alone does not make a global command
        wr(8'h18, 32'h0000_0085);
        chk_vec("R8");
        check(en0 == 64'h20, "R8", en0, 64'h20);

        // R11 gated interrupt sweep
        wr(8'h08, 32'h0);
        wr(8'h0C, 32'h0);
        for (int ch = 0; ch < 64; ch++) begin
            logic [63:0] one;
            one = 64'h1 << ch;
            wr(8'h08, one[31:0]);
            wr(8'h0C, one[63:32]);
            @(negedge clk); err64 = ~one;
            @(negedge clk);
            check(irq0 == 1'b0, "R11 gated", {63'h0, irq0}, 64'h0);
            check(irq1 == 1'b0, "R11 gated", {63'h0, irq1}, 64'h0);
            err64 = one;
            #1;
            check(irq0 == 1'b0, "R11 latency", {63'h0, irq0}, 64'h0);
            @(negedge clk);
            check(irq0 == 1'b1, "R11", {63'h0, irq0}, 64'h1);
            check(irq1 == (ch < 32), "R11", {63'h0, irq1}, {63'h0, ch < 32});
            err64 = '0;
            @(negedge clk);
            check(irq0 == 1'b0, "R11 drop", {63'h0, irq0}, 64'h0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule